// File: doc/BRIEF.md
# Latency-Balanced Pipelined Expression Datapath

This block evaluates the unsigned integer expression ((a*b) * (c*(d+e))) / f on a continuous stream of operand sets. A new set of six operands can be presented on every clock cycle, and one quotient comes out per cycle after a fixed delay. The block is meant to sit in an inner loop of a computational pipeline, where sustained throughput of one result per clock matters more than area.

Each operator has its own fixed latency: the adder takes one cycle, each multiplier two and the divider six. At every point where two branches join, the branch that finishes early passes through delay registers so that both operands reach the next operator in the same cycle. The block uses no FIFO and no sequencing state. A valid bit travels through a shift register of matching length beside the data.

Top module: `expr_pipe`

## Requirements
- R1: For each valid operand set, res_o equals floor(a*b*c*(d+e) / f), computed on unsigned values at full width (4*W+1 bits) with no intermediate truncation.
- R2: The result for an operand set captured at a rising clock edge appears with valid_o high exactly 11 cycles after the cycle in which the set was presented. That is, it is visible after the tenth following rising edge.
- R3: Operand sets presented on consecutive cycles produce results on consecutive cycles, in the same order, with no cycle lost.
- R4: When f is zero, res_o is all ones (every one of its 4*W+1 bits is 1) for that operand set.
- R5: While rst_ni is low, and afterwards until the first valid operand set has passed through, valid_o stays low.
- R6: A cycle with valid_i low yields valid_o low exactly 11 cycles later, so gaps in the input stream reappear unchanged at the output.
- R7: Operands at their maximum value (all ones on every input, f nonzero) give the exact full-width product divided by f, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, clears valid bits |
| valid_i | input | 1 | Operand set on the inputs is valid this cycle |
| a_i | input | W | Operand a |
| b_i | input | W | Operand b |
| c_i | input | W | Operand c |
| d_i | input | W | Operand d |
| e_i | input | W | Operand e |
| f_i | input | W | Divisor f |
| valid_o | output | 1 | res_o holds a result this cycle |
| res_o | output | 4*W+1 | Quotient, or all ones for a zero divisor |

## Verification
A wrong delay on any branch combines operands from different input sets. The bench feeds back-to-back sets with distinct values, so each result carries the wrong mix and fails at the first output 11 cycles after streaming starts. A wrong valid delay shows up at the first output as a result arriving early, late or with no matching input. A width that is too narrow only appears with large operands, which is why the all-ones set is included. Gaps in the input show whether the valid bits stay in step with the data.

// File: rtl/expr_pipe_pkg.sv
package expr_pipe_pkg;
  localparam int unsigned LAT_ADD = 1;
  localparam int unsigned LAT_MUL = 2;
  localparam int unsigned LAT_DIV = 6;
endpackage

// File: rtl/expr_delay.sv
module expr_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1,
  parameter bit          RST   = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] stage_q [DEPTH];
    if (RST) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
      end
    end else begin : g_norst
      always_ff @(posedge clk_i) begin
        stage_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
    end
    assign q_o = stage_q[DEPTH-1];
  end
endmodule

// File: rtl/expr_add.sv
module expr_add #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   s_o
);
  always_ff @(posedge clk_i) s_o <= {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/expr_mul.sv
module expr_mul
  import expr_pipe_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned BW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   a_i,
  input  logic [BW-1:0]   b_i,
  output logic [AW+BW-1:0] p_o
);
  localparam int unsigned PW = AW + BW;
  logic [PW-1:0] prod_q;

  always_ff @(posedge clk_i) prod_q <= PW'(a_i) * PW'(b_i);

  // remaining stages retime the product
  expr_delay #(.W(PW), .DEPTH(LAT_MUL - 1), .RST(1'b0)) u_tail (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(prod_q), .q_o(p_o)
  );
endmodule

// File: rtl/expr_div.sv
module expr_div
  import expr_pipe_pkg::*;
#(
  parameter int unsigned NW = 33,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic [NW-1:0] quo_o
);
  logic [NW-1:0] quo_q;

  always_ff @(posedge clk_i) begin
    if (den_i == '0) quo_q <= '1;
    else             quo_q <= num_i / NW'(den_i);
  end

  expr_delay #(.W(NW), .DEPTH(LAT_DIV - 1), .RST(1'b0)) u_tail (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(quo_q), .q_o(quo_o)
  );
endmodule

// File: rtl/expr_pipe.sv
module expr_pipe
  import expr_pipe_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [W-1:0]     c_i,
  input  logic [W-1:0]     d_i,
  input  logic [W-1:0]     e_i,
  input  logic [W-1:0]     f_i,
  output logic             valid_o,
  output logic [4*W:0]     res_o
);
  localparam int unsigned SW     = W + 1;
  localparam int unsigned ABW    = 2 * W;
  localparam int unsigned CSW    = W + SW;
  localparam int unsigned PW     = ABW + CSW;
  localparam int unsigned AB_DLY = LAT_ADD;             // a*b waits for the adder
  localparam int unsigned C_DLY  = LAT_ADD;
  localparam int unsigned F_DLY  = LAT_ADD + 2 * LAT_MUL;
  localparam int unsigned LAT    = F_DLY + LAT_DIV;
  localparam int unsigned CW     = $clog2(LAT + 1);

  logic [SW-1:0]  sum;
  logic [ABW-1:0] ab, ab_al;
  logic [W-1:0]   c_al, f_al;
  logic [CSW-1:0] cs;
  logic [PW-1:0]  prod;
  logic [0:0]     vld;

  expr_add #(.W(W)) u_add (.clk_i(clk_i), .a_i(d_i), .b_i(e_i), .s_o(sum));

  expr_mul #(.AW(W), .BW(W)) u_mul_ab (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .p_o(ab)
  );
  expr_delay #(.W(ABW), .DEPTH(AB_DLY)) u_dly_ab (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ab), .q_o(ab_al)
  );
  expr_delay #(.W(W), .DEPTH(C_DLY)) u_dly_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(c_i), .q_o(c_al)
  );
  expr_mul #(.AW(W), .BW(SW)) u_mul_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(c_al), .b_i(sum), .p_o(cs)
  );
  expr_mul #(.AW(ABW), .BW(CSW)) u_mul_p (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(ab_al), .b_i(cs), .p_o(prod)
  );
  expr_delay #(.W(W), .DEPTH(F_DLY)) u_dly_f (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(f_i), .q_o(f_al)
  );
  expr_div #(.NW(PW), .DW(W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .num_i(prod), .den_i(f_al), .quo_o(res_o)
  );
  expr_delay #(.W(1), .DEPTH(LAT), .RST(1'b1)) u_dly_v (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(valid_i), .q_o(vld)
  );
  assign valid_o = vld[0];

  // cycles since reset, saturating; gates history-based checks
  logic [CW-1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                warm_q <= '0;
    else if (warm_q < CW'(LAT)) warm_q <= warm_q + 1'b1;
  end

  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= CW'(LAT)) |-> (valid_o == $past(valid_i, LAT)));

  a_r5_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q < CW'(LAT)) |-> !valid_o);

  a_r1_product_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= CW'(F_DLY) && $past(valid_i, F_DLY)) |->
    (prod == $past(PW'(a_i) * PW'(b_i) * PW'(c_i) * (PW'(d_i) + PW'(e_i)), F_DLY)));

  a_r4_zero_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= CW'(LAT) && valid_o && $past(f_i, LAT) == '0) |-> (&res_o));
endmodule

// File: tb/expr_pipe_bench.sv
module expr_pipe_bench;
  localparam int W   = 8;
  localparam int PW  = 4 * W + 1;
  localparam int LAT = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [W-1:0] a, b, c, d, e, f;
  logic valid_o;
  logic [PW-1:0] res_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int outs = 0;

  always #10 clk = ~clk;  // 50 MHz

  expr_pipe #(.W(W)) u_expr_pipe (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .e_i(e), .f_i(f),
    .valid_o(valid_o), .res_o(res_o)
  );

  int          q_cyc [$];
  logic [PW-1:0] q_exp [$];

  function automatic logic [PW-1:0] model(input logic [W-1:0] ma, mb, mc, md, me, mf);
    longint unsigned p;
    p = longint'(ma) * longint'(mb) * longint'(mc) * (longint'(md) + longint'(me));
    if (mf == 0) return '1;
    return PW'(p / longint'(mf));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // capture at edge, compare after settle
  always @(posedge clk) begin
    if (rst_n) begin
      cyc++;
      if (valid_i) begin
        q_cyc.push_back(cyc);
        q_exp.push_back(model(a, b, c, d, e, f));
      end
      #5;
      if (valid_o) begin
        outs++;
        if (q_cyc.size() == 0) begin
          check("R6 unexpected valid_o", 1, 0);
        end else begin
          check("R2 latency", cyc - q_cyc.pop_front(), LAT - 1);
          check("R1 R3 R4 R7 result", res_o, q_exp.pop_front());
        end
      end
    end
  end

  task automatic drive(input logic v, input logic [W-1:0] ia, ib, ic, id, ie, iff_);
    @(negedge clk);
    valid_i = v; a = ia; b = ib; c = ic; d = id; e = ie; f = iff_;
  endtask

  task automatic idle();
    drive(1'b0, 'x, 'x, 'x, 'x, 'x, 'x);
  endtask

  task automatic drain(input string req, input int n_exp, input int outs0);
    idle();
    repeat (LAT + 2) @(negedge clk);
    check({req, " outputs"}, outs - outs0, n_exp);
    check({req, " pending"}, q_cyc.size(), 0);
  endtask

  task automatic test_reset();
    idle();
    repeat (3) @(negedge clk);
    check("R5 valid_o in reset", valid_o, 0);
    rst_n = 1'b1;
    repeat (LAT + 2) @(negedge clk);
    check("R5 valid_o idle after reset", valid_o, 0);
  endtask

  task automatic test_basic();
    int o0 = outs;
    drive(1'b1, 3, 4, 5, 6, 7, 2);
    drain("R1 single", 1, o0);
  endtask

  task automatic test_stream();
    int o0 = outs;
    logic [31:0] s = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      drive(1'b1, s[7:0], s[15:8], s[23:16], s[31:24], s[11:4], s[19:12] | 8'd1);
    end
    drain("R3 stream", 40, o0);
  endtask

  task automatic test_zero_div();
    int o0 = outs;
    drive(1'b1, 9, 9, 9, 9, 9, 0);
    drive(1'b1, 0, 0, 0, 0, 0, 0);
    drive(1'b1, 9, 9, 9, 9, 9, 1);
    drain("R4 zero divisor", 3, o0);
  endtask

  task automatic test_max();
    int o0 = outs;
    drive(1'b1, 8'hff, 8'hff, 8'hff, 8'hff, 8'hff, 8'h01);
    drive(1'b1, 8'hff, 8'hff, 8'hff, 8'hff, 8'hff, 8'hff);
    drive(1'b1, 8'hff, 8'hff, 8'hff, 8'hff, 8'hff, 8'h07);
    drain("R7 max operands", 3, o0);
  endtask

  task automatic test_bubbles();
    int o0 = outs;
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 1) idle();
      else drive(1'b1, 8'(i + 1), 8'(2 * i + 1), 8'(i + 3), 8'(i), 8'(5 * i), 8'(i + 2));
    end
    drain("R6 bubbles", 8, o0);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_basic();
        test_stream();
        test_zero_div();
        test_max();
        test_bubbles();
      end
      begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule